// File: doc/BRIEF.md
# Byte-Wide FPGA Configuration Master

This block configures a downstream FPGA through its byte-wide slave configuration port. A load command makes it restart the target, wait for the target to report that it is ready, and then stream an image of a given length. The image bytes arrive on a valid/ready stream. Each byte is put on the write bus and clocked into the target with one configuration-clock pulse. When stall checking is enabled, the block keeps pulsing the clock without taking a new byte while the target reports a stall. After the last byte it releases select and write, then keeps pulsing until the target reports that it has started up.

A read command runs a readback instead. Select stays asserted, one clock pulse is issued per byte, and the target's read bus is sampled after each rising clock edge and presented on a single-cycle output strobe. One extra pulse with select released closes the readback.

Every wait on the target has a time limit counted in system clock cycles. The configuration clock half-period is a parameter, so that slow boards can be served. Each operation ends with a one-cycle completion pulse and a pass/fail flag. A failed operation also raises an abort pulse and leaves a code that names the phase that ran out of time.

Top module: `fpga_par_cfg_master`

## Requirements
- R1: While reset is held, and in idle afterwards, the outputs sit at these values: restart low, configuration clock high, select low, write low, s_ready low, op_done low, abort low and fail_phase 0.
- R2: When go_load is sampled in idle, restart is high for the next DIV cycles with select and write low. After that the block waits, with restart low, for a cycle in which tgt_clear is 1 and tgt_stall is 0 together. Only then does it request data.
- R3: If the target is not ready in any of the first TMO_CYC cycles of that wait, the block returns to idle and pulses op_done and abort for one cycle. op_ok is 0 and fail_phase is 1.
- R4: Before each byte is accepted, select, write and the configuration clock are high and s_ready is high. A byte is taken in the cycle where s_valid and s_ready are both high.
- R5: An accepted byte appears on tgt_wdata in the next cycle. The clock is then low for DIV cycles and high for DIV cycles, and a single check cycle with the clock high follows. tgt_wdata does not change from acceptance until the next acceptance.
- R6: When busy_chk_en was 1 at the command and tgt_stall is 1 in a check cycle, the block issues another pulse (DIV low, DIV high, check cycle) and takes no byte. When busy_chk_en was 0, tgt_stall in a check cycle has no effect and the next byte is requested.
- R7: A stall that is still present at a check cycle, when the stall phase has lasted TMO_CYC cycles or more counting from the byte's check cycle, ends the load with an abort and fail_phase 2.
- R8: After the last byte's check cycle, select and write go low and the clock stays high for a check cycle. If tgt_live is 1 there, the next cycle shows op_done high with op_ok 1 and fail_phase 0. Otherwise a pulse follows and the check repeats.
- R9: If tgt_live is still 0 at a check cycle, once the completion phase has lasted TMO_CYC cycles or more, the load ends with an abort and fail_phase 3.
- R10: A read command asserts select with write low and issues one pulse per byte. tgt_rdata is sampled in the check cycle after each pulse and shown on rd_data with rd_valid high for the following cycle only. One further pulse with select low follows, and then op_done with op_ok 1.
- R11: An img_len of 0 skips the data phase. A load goes from the ready wait straight to the completion check, and a read issues only the closing pulse.
- R12: Commands are taken only in idle; go_load or go_read during an operation has no effect. If both are high in idle, go_load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| go_load | input | 1 | Start a configuration load (one cycle) |
| go_read | input | 1 | Start a readback (one cycle) |
| img_len | input | LEN_W | Byte count of the image or the readback, taken with the command |
| busy_chk_en | input | 1 | Enable stall handling for this load, taken with the command |
| s_valid | input | 1 | Image byte stream valid |
| s_ready | output | 1 | Image byte stream ready |
| s_data | input | 8 | Image byte |
| tgt_restart | output | 1 | Restart request to the target, active high |
| tgt_clk | output | 1 | Configuration clock |
| tgt_sel | output | 1 | Target select, active high |
| tgt_wen | output | 1 | Write direction, active high |
| tgt_wdata | output | 8 | Write data bus |
| tgt_rdata | input | 8 | Read data bus |
| tgt_clear | input | 1 | Target has finished clearing its memory |
| tgt_stall | input | 1 | Target cannot take data |
| tgt_live | input | 1 | Target has finished starting up |
| rd_valid | output | 1 | Readback byte strobe |
| rd_data | output | 8 | Readback byte |
| op_done | output | 1 | One-cycle end-of-operation pulse |
| op_ok | output | 1 | Result of the last operation, held |
| abort | output | 1 | One-cycle pulse on a timed-out operation |
| fail_phase | output | 2 | 0 none, 1 ready wait, 2 stall, 3 completion; held |

## Verification
The assertions take for granted that reset is low at time zero, that commands last one cycle and arrive only in idle (when one arrives during an operation, the ports must show that it is ignored), and that the target and stream inputs are synchronous to clk. The stimulus drives every input away from the active edge. It holds each target flag at a fixed level for the whole of a check cycle, changes tgt_rdata right after each sampling cycle, and keeps the image stream stable while s_valid is high. The reference model lists the pin values it expects for every cycle, including the stall and completion loops and all three time-outs.

// File: rtl/fpga_par_cfg_master.sv
module fpga_par_cfg_master #(
  parameter int DIV     = 2,
  parameter int TMO_CYC = 500000,
  parameter int LEN_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_load,
  input  logic             go_read,
  input  logic [LEN_W-1:0] img_len,
  input  logic             busy_chk_en,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [7:0]       s_data,
  output logic             tgt_restart,
  output logic             tgt_clk,
  output logic             tgt_sel,
  output logic             tgt_wen,
  output logic [7:0]       tgt_wdata,
  input  logic [7:0]       tgt_rdata,
  input  logic             tgt_clear,
  input  logic             tgt_stall,
  input  logic             tgt_live,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             op_done,
  output logic             op_ok,
  output logic             abort,
  output logic [1:0]       fail_phase
);
  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int WT_W = $clog2(TMO_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_PROG, S_RDY, S_FETCH, S_LO, S_HI, S_CHK} state_t;
  typedef enum logic [2:0] {C_BYTE, C_STALL, C_DONE, C_READ, C_RTAIL} ctx_t;

  state_t           st;
  ctx_t             ctx;
  logic [PH_W-1:0]  ph;
  logic [WT_W-1:0]  wcnt;
  logic [LEN_W-1:0] cnt, len_q;
  logic             bchk_q;
  logic [7:0]       dout_q;

  wire ph_end  = ph == PH_W'(DIV - 1);
  wire tmo_hit = wcnt >= WT_W'(TMO_CYC - 1);
  wire xfer    = (st == S_FETCH) || (st == S_LO) || (st == S_HI) || (st == S_CHK);
  wire wr_ctx  = (ctx == C_BYTE) || (ctx == C_STALL);

  assign tgt_restart = st == S_PROG;
  assign tgt_clk     = st != S_LO;
  assign tgt_sel     = xfer && (wr_ctx || ctx == C_READ);
  assign tgt_wen     = xfer && wr_ctx;
  assign tgt_wdata   = dout_q;
  assign s_ready     = st == S_FETCH;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ctx <= C_BYTE;
      ph <= '0;
      wcnt <= '0;
      cnt <= '0;
      len_q <= '0;
      bchk_q <= 1'b0;
      dout_q <= '0;
      rd_valid <= 1'b0;
      rd_data <= '0;
      op_done <= 1'b0;
      op_ok <= 1'b0;
      abort <= 1'b0;
      fail_phase <= '0;
    end else begin
      op_done <= 1'b0;
      abort <= 1'b0;
      rd_valid <= 1'b0;
      if (!tmo_hit) wcnt <= wcnt + WT_W'(1);
      ph <= ((st == S_PROG || st == S_LO || st == S_HI) && !ph_end) ? ph + PH_W'(1) : '0;
      case (st)
        S_IDLE: begin
          if (go_load || go_read) begin
            len_q <= img_len;
            bchk_q <= busy_chk_en;
            cnt <= '0;
            fail_phase <= '0;
            op_ok <= 1'b0;
            if (go_load) st <= S_PROG;
            else begin
              st <= S_LO;
              ctx <= (img_len == '0) ? C_RTAIL : C_READ;
            end
          end
        end
        S_PROG: if (ph_end) begin
          st <= S_RDY;
          wcnt <= '0;
        end
        S_RDY: begin
          if (tgt_clear && !tgt_stall) begin
            if (len_q == '0) begin
              st <= S_CHK;
              ctx <= C_DONE;
              wcnt <= '0;
            end else begin
              st <= S_FETCH;
              ctx <= C_BYTE;
            end
          end else if (tmo_hit) begin
            st <= S_IDLE;
            op_done <= 1'b1;
            abort <= 1'b1;
            fail_phase <= 2'd1;
          end
        end
        S_FETCH: if (s_valid) begin
          dout_q <= s_data;
          cnt <= cnt + LEN_W'(1);
          st <= S_LO;
        end
        S_LO: if (ph_end) st <= S_HI;
        S_HI: if (ph_end) begin
          st <= S_CHK;
          if (ctx == C_BYTE) wcnt <= '0;
        end
        S_CHK: begin
          case (ctx)
            C_BYTE, C_STALL: begin
              if (bchk_q && tgt_stall) begin
                if (tmo_hit) begin
                  st <= S_IDLE;
                  op_done <= 1'b1;
                  abort <= 1'b1;
                  fail_phase <= 2'd2;
                end else begin
                  ctx <= C_STALL;
                  st <= S_LO;
                end
              end else if (cnt == len_q) begin
                ctx <= C_DONE;
                wcnt <= '0;
              end else begin
                ctx <= C_BYTE;
                st <= S_FETCH;
              end
            end
            C_DONE: begin
              if (tgt_live) begin
                st <= S_IDLE;
                op_done <= 1'b1;
                op_ok <= 1'b1;
              end else if (tmo_hit) begin
                st <= S_IDLE;
                op_done <= 1'b1;
                abort <= 1'b1;
                fail_phase <= 2'd3;
              end else st <= S_LO;
            end
            C_READ: begin
              rd_data <= tgt_rdata;
              rd_valid <= 1'b1;
              cnt <= cnt + LEN_W'(1);
              if (cnt + LEN_W'(1) == len_q) ctx <= C_RTAIL;
              st <= S_LO;
            end
            default: begin
              st <= S_IDLE;
              op_done <= 1'b1;
              op_ok <= 1'b1;
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpga_par_cfg_master_chk.sv
module fpga_par_cfg_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tgt_restart,
  input logic       tgt_clk,
  input logic       tgt_sel,
  input logic       tgt_wen,
  input logic [7:0] tgt_wdata,
  input logic       s_ready,
  input logic       rd_valid,
  input logic       op_done,
  input logic       op_ok,
  input logic       abort,
  input logic [1:0] fail_phase
);
  a_r2_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_restart |-> (!tgt_sel && !tgt_wen && tgt_clk));

  a_r4_setup_before_byte: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (tgt_sel && tgt_wen && tgt_clk));

  a_r5_data_held_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgt_clk && $past(!tgt_clk)) |-> $stable(tgt_wdata));

  a_r5_data_held_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_clk) |-> $stable(tgt_wdata));

  a_r8_write_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_wen |-> tgt_sel);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);

  a_r3_abort_is_failure: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (op_done && !op_ok && fail_phase != 2'd0));

  a_r10_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !tgt_wen);
endmodule

bind fpga_par_cfg_master fpga_par_cfg_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tgt_restart(tgt_restart), .tgt_clk(tgt_clk),
  .tgt_sel(tgt_sel), .tgt_wen(tgt_wen), .tgt_wdata(tgt_wdata), .s_ready(s_ready),
  .rd_valid(rd_valid), .op_done(op_done), .op_ok(op_ok), .abort(abort),
  .fail_phase(fail_phase)
);

// File: tb/fpga_par_cfg_master_test.sv
module fpga_par_cfg_master_test;
  localparam int D = 2;
  localparam int TMO = 40;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go_load = 0, go_read = 0, bchk = 0, s_valid = 0;
  logic [LW-1:0] len = '0;
  logic [7:0] s_data = '0, tgt_rdata = '0;
  logic tgt_clear = 0, tgt_stall = 0, tgt_live = 0;
  logic s_ready, tgt_restart, tgt_clk, tgt_sel, tgt_wen, rd_valid, op_done, op_ok, abort;
  logic [7:0] tgt_wdata, rd_data;
  logic [1:0] fail_phase;

  int n_cmp = 0, n_bad = 0;
  logic [1:0] e_fph = 2'd0;
  logic e_ok = 1'b0;
  logic [7:0] e_dout = 8'h00;
  bit finished = 0;

  always #10 clk = ~clk;

  fpga_par_cfg_master #(.DIV(D), .TMO_CYC(TMO), .LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .go_load(go_load), .go_read(go_read), .img_len(len),
    .busy_chk_en(bchk), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .tgt_restart(tgt_restart), .tgt_clk(tgt_clk), .tgt_sel(tgt_sel), .tgt_wen(tgt_wen),
    .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata), .tgt_clear(tgt_clear),
    .tgt_stall(tgt_stall), .tgt_live(tgt_live), .rd_valid(rd_valid), .rd_data(rd_data),
    .op_done(op_done), .op_ok(op_ok), .abort(abort), .fail_phase(fail_phase)
  );

  task automatic chk(string tg, logic p, logic c, logic s, logic w, logic r,
                     logic od, logic ok, logic ab, logic [1:0] fp, logic rv, logic [7:0] rd);
    logic [10:0] got, exp;
    got = {tgt_restart, tgt_clk, tgt_sel, tgt_wen, s_ready, op_done, op_ok, abort, fail_phase, rd_valid};
    exp = {p, c, s, w, r, od, ok, ab, fp, rv};
    n_cmp++;
    if (got !== exp || tgt_wdata !== e_dout || (rv && rd_data !== rd)) begin
      n_bad++;
      $display("FAIL %s t=%0t pins got %b exp %b wdata got %h exp %h rdata got %h exp %h",
               tg, $time, got, exp, tgt_wdata, e_dout, rd_data, rd);
    end
    @(negedge clk);
  endtask

  task automatic idle_cyc(string tg);
    chk(tg, 0, 1, 0, 0, 0, 0, e_ok, 0, e_fph, 0, 8'h00);
  endtask

  task automatic finish_cyc(string tg);
    chk(tg, 0, 1, 0, 0, 0, 1, e_ok, !e_ok, e_fph, 0, 8'h00);
  endtask

  task automatic pulse(string tg, logic cs, logic wr, logic rdv, logic [7:0] rdd);
    for (int i = 0; i < D; i++) chk(tg, 0, 0, cs, wr, 0, 0, 0, 0, 2'd0, (i == 0) ? rdv : 1'b0, rdd);
    for (int i = 0; i < D; i++) chk(tg, 0, 1, cs, wr, 0, 0, 0, 0, 2'd0, 0, 8'h00);
  endtask

  task automatic run_load(string tg, input logic [7:0] data[$], int rdy_at, input int stall[$],
                          bit bc, int done_at, int gap, bit poke);
    int m, st_i;
    bit rdy;
    len = LW'(data.size()); bchk = bc; go_load = 1; go_read = poke;
    tgt_clear = 0; tgt_stall = 1; tgt_live = 0;
    idle_cyc({tg, " R12"});
    go_load = 0; go_read = 0; e_fph = 2'd0; e_ok = 1'b0;
    for (int i = 0; i < D; i++) chk({tg, " R2"}, 1, 1, 0, 0, 0, 0, 0, 0, 2'd0, 0, 8'h00);
    for (int k = 0; ; k++) begin
      rdy = (rdy_at >= 0) && (k >= rdy_at);
      tgt_clear = rdy ? 1'b1 : (k % 2 == 0);
      tgt_stall = rdy ? 1'b0 : (k % 2 == 0);
      chk({tg, " R2"}, 0, 1, 0, 0, 0, 0, 0, 0, 2'd0, 0, 8'h00);
      if (rdy) break;
      if (k + 1 >= TMO) begin
        tgt_clear = 0; tgt_stall = 0; e_fph = 2'd1;
        finish_cyc({tg, " R3"}); idle_cyc({tg, " R3"});
        return;
      end
    end
    tgt_clear = 1; tgt_stall = 0;
    foreach (data[i]) begin
      if (poke && i == 0) begin go_load = 1; go_read = 1; end
      for (int g = 0; g < gap; g++) begin
        s_valid = 0;
        chk({tg, " R4"}, 0, 1, 1, 1, 1, 0, 0, 0, 2'd0, 0, 8'h00);
        go_load = 0; go_read = 0;
      end
      s_valid = 1; s_data = data[i];
      chk({tg, " R4"}, 0, 1, 1, 1, 1, 0, 0, 0, 2'd0, 0, 8'h00);
      go_load = 0; go_read = 0;
      s_valid = 0; s_data = ~data[i]; e_dout = data[i];
      pulse({tg, " R5"}, 1, 1, 0, 8'h00);
      st_i = (i < stall.size()) ? stall[i] : 0;
      m = 0;
      forever begin
        tgt_stall = (m < st_i);
        chk({tg, " R6"}, 0, 1, 1, 1, 0, 0, 0, 0, 2'd0, 0, 8'h00);
        if (bc && tgt_stall) begin
          if (1 + m * (2 * D + 1) >= TMO) begin
            tgt_stall = 0; e_fph = 2'd2;
            finish_cyc({tg, " R7"}); idle_cyc({tg, " R7"});
            return;
          end
          pulse({tg, " R6"}, 1, 1, 0, 8'h00);
          m++;
        end else break;
      end
      tgt_stall = 0;
    end
    m = 0;
    forever begin
      tgt_live = (done_at >= 0) && (m >= done_at);
      chk({tg, " R8"}, 0, 1, 0, 0, 0, 0, 0, 0, 2'd0, 0, 8'h00);
      if (tgt_live) begin
        tgt_live = 0; e_ok = 1'b1;
        finish_cyc({tg, " R8"}); idle_cyc({tg, " R8"});
        return;
      end
      if (1 + m * (2 * D + 1) >= TMO) begin
        e_fph = 2'd3;
        finish_cyc({tg, " R9"}); idle_cyc({tg, " R9"});
        return;
      end
      pulse({tg, " R8"}, 0, 0, 0, 8'h00);
      m++;
    end
  endtask

  task automatic run_read(string tg, input logic [7:0] vals[$]);
    logic rv;
    logic [7:0] rd;
    len = LW'(vals.size()); go_read = 1;
    idle_cyc({tg, " R12"});
    go_read = 0; e_fph = 2'd0; e_ok = 1'b0; rv = 0; rd = 8'h00;
    foreach (vals[j]) begin
      pulse({tg, " R10"}, 1, 0, rv, rd);
      tgt_rdata = vals[j];
      chk({tg, " R10"}, 0, 1, 1, 0, 0, 0, 0, 0, 2'd0, 0, 8'h00);
      tgt_rdata = ~vals[j]; rv = 1; rd = vals[j];
    end
    pulse({tg, " R10"}, 0, 0, rv, rd);
    chk({tg, " R10"}, 0, 1, 0, 0, 0, 0, 0, 0, 2'd0, 0, 8'h00);
    e_ok = 1'b1;
    finish_cyc({tg, " R10"}); idle_cyc({tg, " R10"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired, got running exp finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] q[$];
    int sq[$];
    @(negedge clk);
    for (int i = 0; i < 2; i++) chk("R1 reset", 0, 1, 0, 0, 0, 0, 0, 0, 2'd0, 0, 8'h00);
    rst_n = 1;
    for (int i = 0; i < 2; i++) idle_cyc("R1 idle");

    q = {8'hA5, 8'h3C, 8'h01}; sq = {};
    run_load("basic", q, 3, sq, 1, 0, 0, 0);

    q = {8'h5A, 8'hF0, 8'h0F}; sq = {0, 2, 0};
    run_load("stall", q, 0, sq, 1, 2, 2, 1);

    q = {8'h77, 8'h88}; sq = {3, 0};
    run_load("stall off", q, 1, sq, 0, 1, 1, 0);

    q = {8'h11}; sq = {};
    run_load("ready timeout", q, -1, sq, 1, 0, 0, 0);

    q = {8'h22, 8'h33}; sq = {0, 100};
    run_load("stall timeout", q, 0, sq, 1, 0, 0, 0);

    q = {8'hC3}; sq = {};
    run_load("done timeout", q, 2, sq, 0, -1, 0, 0);

    q = {}; sq = {};
    run_load("R11 empty load", q, 1, sq, 1, 1, 0, 0);

    q = {8'h96, 8'h69, 8'hE1};
    run_read("readback", q);

    q = {};
    run_read("R11 empty read", q);

    q = {8'hB4}; sq = {};
    run_load("R12 priority", q, 0, sq, 1, 0, 0, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule